// File: doc/BRIEF.md
# I2C Command Bridge

This block sits between a byte-wide command channel, such as one fed from a serial or USB link, and a byte-level I2C transfer engine. A host sends a command as a short frame. The first byte is a header whose lowest bit picks the direction. The second byte is a byte count. A write frame then carries that many data bytes. The bridge turns each frame into a run of engine requests. It marks the final request so that the engine closes the bus transaction with a stop condition. It then answers on a byte-wide response channel.

A write frame is answered with one status byte, sent after every engine response for that frame has arrived. A read frame is answered at once with a status byte, followed by the read bytes in the order the engine returns them. Every channel uses a valid/ready handshake. The command parser can take in the next frame's header while the previous frame's responses are still draining. The bridge also publishes the engine's bit period in system clock cycles, which it derives from its two frequency parameters.

Top module: `i2c_cmd_bridge`

## Requirements
- R1: Bit 0 of a header byte selects the direction: 1 is read and 0 is write. Header bits 7..1 have no effect.
- R2: The byte after the header is a count N. The frame produces exactly N engine requests, and for a write exactly N further command bytes are consumed.
- R3: Each write data byte is passed to the engine in order, with the read flag low.
- R4: A read frame consumes no data bytes and issues N requests with the read flag high. Its response is a status byte 0x00 followed by the N engine data bytes in order.
- R5: The status byte of a write is 0x01 if any engine response of that frame reports a missing acknowledge, and 0x00 otherwise. It is sent only after all N engine responses.
- R6: The engine's last flag is high on the N-th request of a frame and low on every other request.
- R7: A count of zero produces no engine request. The only response is the status byte 0x00, for both directions.
- R8: Under backpressure on any channel no byte is lost or duplicated. A valid output that is not accepted keeps its value until it is taken.
- R9: `eng_period_cyc` equals SYS_CLK_HZ / I2C_HZ, which is 250 with the defaults of 100 MHz and 400 kHz.
- R10: While reset is held, and in the first cycle after it, both output valids are low. Once reset is released the bridge is ready for a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command byte offered |
| cmd_ready | output | 1 | Command byte accepted |
| cmd_data | input | DATA_W | Command byte (header, count or write data) |
| rsp_valid | output | 1 | Response byte offered |
| rsp_ready | input | 1 | Response byte taken |
| rsp_data | output | DATA_W | Status or read data byte |
| eng_req_valid | output | 1 | Engine request offered |
| eng_req_ready | input | 1 | Engine request taken |
| eng_req_rd | output | 1 | 1 = read one byte, 0 = write one byte |
| eng_req_data | output | DATA_W | Byte to write (zero for reads) |
| eng_req_last | output | 1 | Final byte of the transaction; engine ends it with a stop |
| eng_rsp_valid | input | 1 | Engine result offered |
| eng_rsp_ready | output | 1 | Engine result taken |
| eng_rsp_data | input | DATA_W | Byte read from the bus |
| eng_rsp_nack | input | 1 | Target did not acknowledge the byte |
| eng_period_cyc | output | PERIOD_W | Bit period in system clock cycles |

## Verification
The frames are first run with every handshake always ready. These cases separate the zero-count forms, headers with the upper bits set, and missing acknowledges on the first or a middle byte. This shows that status ordering, the error value and the count logic are right without interference from stalls. The same mix of random frames is then run with moderate stalls and then with heavy random stalls on all four channels. This exposes any byte that is dropped or repeated when the command, engine and response sides stall independently. Back-to-back frames of mixed direction check that a new header parsed early never overtakes the responses still owed to the previous frame.

// File: rtl/i2cb_pkg.sv
// Shared types for the I2C command bridge.
// Assumes: byte-wide channels; state encodings are local to this block.
package i2cb_pkg;

    // Command-side sequencer states
    typedef enum logic [1:0] {
        ISS_HDR  = 2'd0,
        ISS_CNT  = 2'd1,
        ISS_JOB  = 2'd2,
        ISS_XFER = 2'd3
    } iss_state_e;

    // Response-side collector states
    typedef enum logic [1:0] {
        COL_IDLE = 2'd0,
        COL_STAT = 2'd1,
        COL_RDAT = 2'd2,
        COL_WCOL = 2'd3
    } col_state_e;

endpackage

// File: rtl/i2cb_issuer.sv
// Command-side sequencer. It parses header and count bytes, hands the frame
// description to the collector, then issues engine requests.
// Assumes: write data is passed straight through (no storage), so cmd_ready
// follows eng_req_ready during a write transfer.
module i2cb_issuer
    import i2cb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              job_valid,
    input  logic              job_ready,
    output logic              job_rd,
    output logic [DATA_W-1:0] job_cnt,
    output logic              eng_req_valid,
    input  logic              eng_req_ready,
    output logic              eng_req_rd,
    output logic [DATA_W-1:0] eng_req_data,
    output logic              eng_req_last
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    iss_state_e        state_q;
    logic              rd_q;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] left_q;
    logic              req_fire;

    // Handshake steering per state
    always_comb begin
        cmd_ready     = 1'b0;
        job_valid     = 1'b0;
        eng_req_valid = 1'b0;
        eng_req_data  = '0;
        case (state_q)
            ISS_HDR:  cmd_ready = 1'b1;
            ISS_CNT:  cmd_ready = 1'b1;
            ISS_JOB:  job_valid = 1'b1;
            ISS_XFER: begin
                if (rd_q) begin
                    eng_req_valid = 1'b1;
                end else begin
                    eng_req_valid = cmd_valid;
                    eng_req_data  = cmd_data;
                    cmd_ready     = eng_req_ready;
                end
            end
            default: ;
        endcase
    end

    assign req_fire     = eng_req_valid && eng_req_ready;
    assign eng_req_rd   = rd_q;
    assign eng_req_last = (left_q == ONE);
    assign job_rd       = rd_q;
    assign job_cnt      = cnt_q;

    // Frame parsing and remaining-byte count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ISS_HDR;
            rd_q    <= 1'b0;
            cnt_q   <= '0;
            left_q  <= '0;
        end else begin
            case (state_q)
                ISS_HDR: if (cmd_valid) begin
                    rd_q    <= cmd_data[0];
                    state_q <= ISS_CNT;
                end
                ISS_CNT: if (cmd_valid) begin
                    cnt_q   <= cmd_data;
                    left_q  <= cmd_data;
                    state_q <= ISS_JOB;
                end
                ISS_JOB: if (job_ready) begin
                    state_q <= (left_q == '0) ? ISS_HDR : ISS_XFER;
                end
                ISS_XFER: if (req_fire) begin
                    left_q <= left_q - ONE;
                    if (left_q == ONE) state_q <= ISS_HDR;
                end
                default: state_q <= ISS_HDR;
            endcase
        end
    end

endmodule

// File: rtl/i2cb_collector.sv
// Response-side sequencer. For reads it sends status 0 first, then forwards
// engine bytes. For writes it absorbs engine results, ORs the missing
// acknowledge flags, then sends one status byte.
// Assumes: one engine result per engine request, returned in order.
module i2cb_collector
    import i2cb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              job_valid,
    output logic              job_ready,
    input  logic              job_rd,
    input  logic [DATA_W-1:0] job_cnt,
    input  logic              eng_rsp_valid,
    output logic              eng_rsp_ready,
    input  logic [DATA_W-1:0] eng_rsp_data,
    input  logic              eng_rsp_nack,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_data
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    col_state_e        state_q;
    logic              rd_q;
    logic              err_q;
    logic [DATA_W-1:0] left_q;
    logic              ersp_fire;

    // Output steering per state
    always_comb begin
        job_ready     = (state_q == COL_IDLE);
        eng_rsp_ready = 1'b0;
        rsp_valid     = 1'b0;
        rsp_data      = '0;
        case (state_q)
            COL_STAT: begin
                rsp_valid = 1'b1;
                rsp_data  = {{(DATA_W-1){1'b0}}, err_q};
            end
            COL_RDAT: begin
                rsp_valid     = eng_rsp_valid;
                rsp_data      = eng_rsp_data;
                eng_rsp_ready = rsp_ready;
            end
            COL_WCOL: eng_rsp_ready = 1'b1;
            default: ;
        endcase
    end

    assign ersp_fire = eng_rsp_valid && eng_rsp_ready;

    // Frame tracking, error accumulation and ordering of status vs data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= COL_IDLE;
            rd_q    <= 1'b0;
            err_q   <= 1'b0;
            left_q  <= '0;
        end else begin
            case (state_q)
                COL_IDLE: if (job_valid) begin
                    rd_q    <= job_rd;
                    err_q   <= 1'b0;
                    left_q  <= job_cnt;
                    state_q <= (job_rd || job_cnt == '0) ? COL_STAT : COL_WCOL;
                end
                COL_STAT: if (rsp_ready) begin
                    state_q <= (rd_q && left_q != '0) ? COL_RDAT : COL_IDLE;
                end
                COL_RDAT: if (ersp_fire) begin
                    left_q <= left_q - ONE;
                    if (left_q == ONE) state_q <= COL_IDLE;
                end
                COL_WCOL: if (ersp_fire) begin
                    err_q  <= err_q | eng_rsp_nack;
                    left_q <= left_q - ONE;
                    if (left_q == ONE) state_q <= COL_STAT;
                end
                default: state_q <= COL_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/i2c_cmd_bridge.sv
// Top of the I2C command bridge. It joins the command sequencer and the
// response collector through a one-entry frame handoff, and publishes the
// engine bit period.
// Assumes: the engine returns one result per request, in order.
module i2c_cmd_bridge #(
    parameter int SYS_CLK_HZ = 100_000_000,
    parameter int I2C_HZ     = 400_000,
    parameter int DATA_W     = 8,
    parameter int PERIOD_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [DATA_W-1:0]   cmd_data,
    output logic                rsp_valid,
    input  logic                rsp_ready,
    output logic [DATA_W-1:0]   rsp_data,
    output logic                eng_req_valid,
    input  logic                eng_req_ready,
    output logic                eng_req_rd,
    output logic [DATA_W-1:0]   eng_req_data,
    output logic                eng_req_last,
    input  logic                eng_rsp_valid,
    output logic                eng_rsp_ready,
    input  logic [DATA_W-1:0]   eng_rsp_data,
    input  logic                eng_rsp_nack,
    output logic [PERIOD_W-1:0] eng_period_cyc
);

    localparam int PERIOD_CYC = SYS_CLK_HZ / I2C_HZ;

    logic              job_valid;
    logic              job_ready;
    logic              job_rd;
    logic [DATA_W-1:0] job_cnt;

    // Bit period handed to the engine
    assign eng_period_cyc = PERIOD_W'(PERIOD_CYC);

    i2cb_issuer #(.DATA_W(DATA_W)) u_issuer (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_ready     (cmd_ready),
        .cmd_data      (cmd_data),
        .job_valid     (job_valid),
        .job_ready     (job_ready),
        .job_rd        (job_rd),
        .job_cnt       (job_cnt),
        .eng_req_valid (eng_req_valid),
        .eng_req_ready (eng_req_ready),
        .eng_req_rd    (eng_req_rd),
        .eng_req_data  (eng_req_data),
        .eng_req_last  (eng_req_last)
    );

    i2cb_collector #(.DATA_W(DATA_W)) u_collector (
        .clk           (clk),
        .rst_n         (rst_n),
        .job_valid     (job_valid),
        .job_ready     (job_ready),
        .job_rd        (job_rd),
        .job_cnt       (job_cnt),
        .eng_rsp_valid (eng_rsp_valid),
        .eng_rsp_ready (eng_rsp_ready),
        .eng_rsp_data  (eng_rsp_data),
        .eng_rsp_nack  (eng_rsp_nack),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_data      (rsp_data)
    );

endmodule

// File: rtl/i2c_cmd_bridge_chk.sv
// Protocol checker for the I2C command bridge, bound to the top module.
// Assumes: the environment holds its own valid/data stable until accepted.
module i2c_cmd_bridge_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [DATA_W-1:0] rsp_data,
    input logic              eng_req_valid,
    input logic              eng_req_ready,
    input logic              eng_req_rd,
    input logic [DATA_W-1:0] eng_req_data,
    input logic              eng_req_last
);

    // A stalled response byte stays offered and unchanged
    assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

    // A stalled engine request stays offered and unchanged
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req_valid && !eng_req_ready |=> eng_req_valid && $stable(eng_req_data)
            && $stable(eng_req_rd) && $stable(eng_req_last));

    // Read requests never consume a command byte
    assert_rd_no_payload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req_valid && eng_req_rd |-> !cmd_ready);

    // First cycle out of reset offers nothing
    assert_reset_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !rsp_valid && !eng_req_valid);

endmodule

bind i2c_cmd_bridge i2c_cmd_bridge_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_ready     (cmd_ready),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_data      (rsp_data),
    .eng_req_valid (eng_req_valid),
    .eng_req_ready (eng_req_ready),
    .eng_req_rd    (eng_req_rd),
    .eng_req_data  (eng_req_data),
    .eng_req_last  (eng_req_last)
);

// File: tb/i2c_cmd_bridge_test.sv
`timescale 1ns/1ps
module i2c_cmd_bridge_test;

    localparam int SYS_HZ = 100_000_000;
    localparam int BUS_HZ = 400_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [7:0]  cmd_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [7:0]  rsp_data;
    logic        eng_req_valid;
    logic        eng_req_ready = 1'b0;
    logic        eng_req_rd;
    logic [7:0]  eng_req_data;
    logic        eng_req_last;
    logic        eng_rsp_valid = 1'b0;
    logic        eng_rsp_ready;
    logic [7:0]  eng_rsp_data = '0;
    logic        eng_rsp_nack = 1'b0;
    logic [15:0] eng_period_cyc;

    always #2 clk = ~clk;

    i2c_cmd_bridge #(.SYS_CLK_HZ(SYS_HZ), .I2C_HZ(BUS_HZ), .DATA_W(8), .PERIOD_W(16)) uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .eng_req_valid(eng_req_valid), .eng_req_ready(eng_req_ready),
        .eng_req_rd(eng_req_rd), .eng_req_data(eng_req_data), .eng_req_last(eng_req_last),
        .eng_rsp_valid(eng_rsp_valid), .eng_rsp_ready(eng_rsp_ready),
        .eng_rsp_data(eng_rsp_data), .eng_rsp_nack(eng_rsp_nack),
        .eng_period_cyc(eng_period_cyc)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int n_req_seen = 0;
    int p_cmd = 100, p_req = 100, p_ersp = 100, p_rsp = 100;

    logic [7:0] cmd_q[$];
    logic       qreq_rd[$];
    logic [7:0] qreq_data[$];
    logic       qreq_last[$];
    logic [7:0] qreq_rsp[$];
    logic       qreq_nack[$];
    logic [7:0] pend_data[$];
    logic       pend_nack[$];
    logic [7:0] exp_rsp[$];
    string      exp_tag[$];

    function automatic bit roll(input int pct);
        return int'($urandom_range(99)) < pct;
    endfunction

    function automatic logic [7:0] hdr_byte(input bit rd, input logic [6:0] hi);
        return {hi, rd};
    endfunction

    function automatic logic [7:0] exp_status(input logic any_nack);
        return any_nack ? 8'h01 : 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv, input string what);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // Queue one command frame and its expected engine and response traffic
    task automatic add_cmd(input bit rd, input int len, input logic [6:0] hi,
                           input int nack_pct, input int nack_at);
        logic any_n;
        logic [7:0] b;
        logic n;
        any_n = 1'b0;
        cmd_q.push_back(hdr_byte(rd, hi));
        cmd_q.push_back(8'(len));
        if (rd) begin
            exp_rsp.push_back(8'h00);
            exp_tag.push_back(len == 0 ? "R7" : "R4");
            for (int i = 0; i < len; i++) begin
                b = 8'($urandom);
                qreq_rd.push_back(1'b1); qreq_data.push_back(8'h00);
                qreq_last.push_back(i == len - 1);
                qreq_rsp.push_back(b); qreq_nack.push_back(1'b0);
                exp_rsp.push_back(b); exp_tag.push_back("R4");
            end
        end else begin
            for (int i = 0; i < len; i++) begin
                b = 8'($urandom);
                n = (i == nack_at) || roll(nack_pct);
                any_n = any_n | n;
                cmd_q.push_back(b);
                qreq_rd.push_back(1'b0); qreq_data.push_back(b);
                qreq_last.push_back(i == len - 1);
                qreq_rsp.push_back(8'($urandom)); qreq_nack.push_back(n);
            end
            exp_rsp.push_back(exp_status(any_n));
            exp_tag.push_back(len == 0 ? "R7" : "R5");
        end
    endtask

    // Command source: holds each byte until accepted
    bit cmd_fire = 1'b0;
    initial forever begin
        @(negedge clk);
        if (cmd_fire) begin void'(cmd_q.pop_front()); cmd_valid = 1'b0; end
        if (!cmd_valid && cmd_q.size() > 0 && roll(p_cmd)) begin
            cmd_valid = 1'b1; cmd_data = cmd_q[0];
        end
        #1;
        cmd_fire = rst_n && cmd_valid && cmd_ready;
    end

    // Engine request side: random ready, compares each accepted request
    initial forever begin
        @(negedge clk);
        eng_req_ready = roll(p_req);
        #1;
        if (rst_n && eng_req_valid && eng_req_ready) begin
            n_req_seen++;
            if (qreq_rd.size() == 0) begin
                chk("R2", 32'd1, 32'd0, "unexpected engine request");
            end else begin
                chk("R1", 32'(eng_req_rd), 32'(qreq_rd[0]), "request direction");
                if (!qreq_rd[0]) chk("R3", 32'(eng_req_data), 32'(qreq_data[0]), "write byte");
                chk("R6", 32'(eng_req_last), 32'(qreq_last[0]), "last flag");
                pend_data.push_back(qreq_rsp[0]); pend_nack.push_back(qreq_nack[0]);
                void'(qreq_rd.pop_front()); void'(qreq_data.pop_front());
                void'(qreq_last.pop_front()); void'(qreq_rsp.pop_front());
                void'(qreq_nack.pop_front());
            end
        end
    end

    // Engine result side: returns one result per accepted request, in order
    bit ersp_fire = 1'b0;
    initial forever begin
        @(negedge clk);
        if (ersp_fire) begin
            void'(pend_data.pop_front()); void'(pend_nack.pop_front());
            eng_rsp_valid = 1'b0;
        end
        if (!eng_rsp_valid && pend_data.size() > 0 && roll(p_ersp)) begin
            eng_rsp_valid = 1'b1; eng_rsp_data = pend_data[0]; eng_rsp_nack = pend_nack[0];
        end
        #1;
        ersp_fire = rst_n && eng_rsp_valid && eng_rsp_ready;
    end

    // Response sink: random ready, hold check, ordered compare
    bit held = 1'b0;
    logic [7:0] held_data = '0;
    initial forever begin
        @(negedge clk);
        rsp_ready = roll(p_rsp);
        #1;
        if (rst_n && held) chk("R8", {23'd0, rsp_valid, rsp_data}, {23'd0, 1'b1, held_data}, "stalled response held");
        held = rst_n && rsp_valid && !rsp_ready;
        held_data = rsp_data;
        if (rst_n && rsp_valid && rsp_ready) begin
            if (exp_rsp.size() == 0) begin
                chk("R8", 32'd1, 32'd0, "extra response byte");
            end else begin
                chk(exp_tag[0], 32'(rsp_data), 32'(exp_rsp[0]), "response byte");
                void'(exp_rsp.pop_front()); void'(exp_tag.pop_front());
            end
        end
    end

    bit timed_out = 1'b0;
    task automatic drain();
        int cyc = 0;
        while ((cmd_q.size() != 0 || qreq_rd.size() != 0 || pend_data.size() != 0
                || exp_rsp.size() != 0) && cyc < 60000) begin
            @(posedge clk); cyc++;
        end
        if (cyc >= 60000) begin
            timed_out = 1'b1;
            chk("R8", 32'd1, 32'd0, "watchdog expired, traffic stuck");
        end
        repeat (10) @(posedge clk);
    endtask

    initial begin
        void'($urandom(32'd13579));
        repeat (4) @(posedge clk);
        @(negedge clk); #2;
        chk("R10", {30'd0, rsp_valid, eng_req_valid}, 32'd0, "valids in reset");
        rst_n = 1'b1;
        @(negedge clk); #2;
        chk("R10", {29'd0, rsp_valid, eng_req_valid, cmd_ready}, 32'd1, "state after reset");
        chk("R9", 32'(eng_period_cyc), 32'(SYS_HZ / BUS_HZ), "bit period");

        // R7: zero-count frames, both directions
        add_cmd(1'b0, 0, 7'h00, 0, -1);
        add_cmd(1'b1, 0, 7'h00, 0, -1);
        drain();
        chk("R7", 32'(n_req_seen), 32'd0, "engine requests for zero counts");

        // R1: upper header bits set; R5: missing acknowledge first and middle
        add_cmd(1'b0, 3, 7'h7F, 0, -1);
        add_cmd(1'b1, 2, 7'h40, 0, -1);
        add_cmd(1'b0, 1, 7'h15, 0, 0);
        add_cmd(1'b0, 4, 7'h2A, 0, 1);
        add_cmd(1'b1, 1, 7'h7F, 0, -1);
        drain();

        // Random frames, moderate stalls
        p_cmd = 60; p_req = 60; p_ersp = 60; p_rsp = 60;
        for (int k = 0; k < 40 && !timed_out; k++)
            add_cmd(1'($urandom), int'($urandom_range(7)), 7'($urandom), 15, -1);
        drain();

        // Random frames, heavy stalls
        p_cmd = 30; p_req = 25; p_ersp = 35; p_rsp = 20;
        for (int k = 0; k < 30 && !timed_out; k++)
            add_cmd(1'($urandom), int'($urandom_range(9)), 7'($urandom), 20, -1);
        drain();

        chk("R2", 32'(cmd_q.size() + qreq_rd.size() + pend_data.size()), 32'd0, "traffic drained");
        @(negedge clk); #2;
        chk("R8", {31'd0, rsp_valid}, 32'd0, "no response after drain");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule